// File: doc/BRIEF.md
# One-Hot Fuse Programming and Readback Controller

This block gives permanent programming and readback of a modelled fuse array that holds a switch's configuration: an 8-bit switchpoint magnitude, a 1-bit switchpoint polarity and a combined output/lock field. A separate key decoder reports when a register-and-mode key has finished, and which register and mode it named. After that it sends one strobe at the end of each mid-level pulse and one strobe, with the measured width in clock cycles, at the end of each high-level pulse.

Fuses are addressed one bit at a time through a one-hot pointer that starts at the least significant bit and moves up one place per mid pulse. A code with several set bits must therefore be split into its single bits. Each bit is blown in its own power cycle: a long high pulse blows the pointed bit, and the controller then stays inert until the next power-on reset. In read mode the output pin shows, for each addressed bit, low for a blown fuse and high for an intact one. Once the lock fuse is blown, no further key opens a session.

The power-on reset `rst_n` leaves the fuses untouched. `fab_init_n` stands for the blank array as it comes from manufacture and clears every fuse.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: A `key_done` strobe that names a valid register while the device is unlocked and no blow has yet happened in this power cycle opens a session, and the address is then bit 0 (code 1).
- R2: Each `mid_stb` moves the one-hot address one place up, so n strobes address bit n. A move past the top bit of the selected field leaves no bit addressed, and a blow pulse given then changes no fuse.
- R3: In blow mode, a `high_stb` whose `high_len` is at least `BLOW_CYC` sets only the addressed bit of the selected field, one cycle after the strobe.
- R4: In blow mode, a `high_stb` whose `high_len` is below `BLOW_CYC` blows nothing and closes the session, so a new key is needed. In read mode, any `high_stb` closes the session.
- R5: After an accepted blow pulse (long enough, with or without an addressed bit), all inputs are ignored until `rst_n` is asserted. At most one fuse bit changes per power cycle, and `rst_n` does not clear fuses.
- R6: A blown bit is never cleared. Other bits of the same field can still be blown in later power cycles, in any order.
- R7: In read mode, `read_out` is 0 when the addressed fuse is blown and 1 when it is intact. It is valid from the cycle after the key strobe and after each mid strobe. It is 1 outside a read session and when no bit is addressed.
- R8: Read mode shows the raw fuse value and does not depend on the output-polarity fuse, so that fuse (output/lock field bit 2) reads back directly.
- R9: When the lock fuse (output/lock field bit 4, reached with four mid strobes) is blown, `key_done` is ignored for both modes: no read session and no blow.
- R10: `key_reg` encoding: 0 selects the magnitude field (8 bits), 1 the polarity field (1 bit), 2 the output/lock field (5 bits: fall time in bits 1:0, output polarity in bit 2, a spare bit 3, lock in bit 4), and 3 is not a register, so its key is ignored. `key_read` is 1 for read mode and 0 for blow mode.
- R11: While `fab_init_n` is low, every fuse is cleared.
- R12: A `key_done` in the same cycle as a `mid_stb` or `high_stb` takes precedence: the session restarts and the strobe is discarded, so nothing is blown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low; fuses are kept |
| fab_init_n | input | 1 | Blank-array initialisation, active low; clears all fuses |
| key_done | input | 1 | One-cycle strobe: register and mode key complete |
| key_reg | input | 2 | Register named by the key (R10 encoding) |
| key_read | input | 1 | 1 = read mode, 0 = blow mode |
| mid_stb | input | 1 | One-cycle strobe at the end of a mid-level pulse |
| high_stb | input | 1 | One-cycle strobe at the end of a high-level pulse |
| high_len | input | LEN_W | Measured width of that high pulse in cycles |
| read_out | output | 1 | Readback pin level: 0 blown, 1 intact or idle |
| f_mag | output | MAG_W | Magnitude fuse field |
| f_swpol | output | 1 | Switchpoint polarity fuse |
| f_fall | output | FALL_W | Fall-time fuse field |
| f_opol | output | 1 | Output polarity fuse |
| f_lock | output | 1 | Lock fuse |

## Verification
Two events can meet in one cycle: a fresh key strobe and a pending blow pulse or address step in an open blow session. The bench provokes this by raising `key_done` together with a long `high_stb` (and, separately, with a `mid_stb`) after moving the pointer up. It judges the result by the fuse outputs, which must stay unchanged, and by a following read session whose pin levels must match the pre-collision model. Random blow, read and short-pulse sequences from a fixed seed are checked against a per-field bench model of the fuse bits.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OPEN  = 2'd1,
    S_SPENT = 2'd2
  } seq_t;

  typedef enum logic [1:0] {
    REG_MAG   = 2'd0,
    REG_SWPOL = 2'd1,
    REG_OUTLK = 2'd2,
    REG_NONE  = 2'd3
  } regsel_t;

  // Bits a register owns inside the one-hot address space.
  function automatic logic [31:0] field_mask(regsel_t r, int unsigned mag_w, int unsigned ol_w);
    logic [31:0] m;
    case (r)
      REG_MAG:   m = (32'h1 << mag_w) - 32'h1;
      REG_SWPOL: m = 32'h1;
      REG_OUTLK: m = (32'h1 << ol_w) - 32'h1;
      default:   m = 32'h0;
    endcase
    return m;
  endfunction

  // One place up; anything leaving the field vanishes.
  function automatic logic [31:0] step_addr(logic [31:0] a, logic [31:0] mask);
    return (a << 1) & mask;
  endfunction

  function automatic logic long_enough(logic [31:0] len, int unsigned min_len);
    return len >= min_len;
  endfunction

endpackage

// File: rtl/fuse_addr_shift.sv
module fuse_addr_shift
  import fusectl_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          clear,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr
);
  logic [31:0] nxt32;
  logic [AW-1:0] nxt;

  assign nxt32 = step_addr(32'(addr), 32'(mask));
  assign nxt   = nxt32[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= AW'(1);
    else if (clear)  addr <= '0;
    else if (step)   addr <= nxt;
  end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fusectl_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BLOW_CYC = 4500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_done,
  input  logic [1:0]       key_reg,
  input  logic             key_read,
  input  logic             mid_stb,
  input  logic             high_stb,
  input  logic [LEN_W-1:0] high_len,
  input  logic             locked,
  output logic             load,
  output logic             step,
  output logic             clear,
  output logic             blow_fire,
  output logic             read_act,
  output regsel_t          cur_reg,
  output seq_t             state
);
  logic    cur_read;
  logic    key_ok;
  logic    is_long;
  seq_t    state_nx;

  assign key_ok  = key_done && !locked && (regsel_t'(key_reg) != REG_NONE)
                   && (state != S_SPENT);
  assign is_long = long_enough(32'(high_len), BLOW_CYC);

  always_comb begin
    state_nx  = state;
    load      = 1'b0;
    step      = 1'b0;
    clear     = 1'b0;
    blow_fire = 1'b0;
    if (key_ok) begin
      state_nx = S_OPEN;
      load     = 1'b1;
    end else if (state == S_OPEN && high_stb) begin
      clear = 1'b1;
      if (!cur_read && is_long) begin
        blow_fire = 1'b1;
        state_nx  = S_SPENT;
      end else begin
        state_nx = S_IDLE;
      end
    end else if (state == S_OPEN && mid_stb) begin
      step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_reg  <= REG_NONE;
      cur_read <= 1'b0;
    end else begin
      state <= state_nx;
      if (key_ok) begin
        cur_reg  <= regsel_t'(key_reg);
        cur_read <= key_read;
      end
    end
  end

  assign read_act = (state == S_OPEN) && cur_read;
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fusectl_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned MAG_W = 8,
  parameter int unsigned OL_W  = 5
) (
  input  logic             clk,
  input  logic             fab_init_n,
  input  logic             blow_en,
  input  regsel_t          blow_reg,
  input  logic [AW-1:0]    blow_addr,
  output logic [MAG_W-1:0] mag,
  output logic             sp,
  output logic [OL_W-1:0]  ol
);
  always_ff @(posedge clk) begin
    if (!fab_init_n) begin
      mag <= '0;
      sp  <= 1'b0;
      ol  <= '0;
    end else if (blow_en) begin
      case (blow_reg)
        REG_MAG:   mag <= mag | blow_addr[MAG_W-1:0];
        REG_SWPOL: sp  <= sp | blow_addr[0];
        REG_OUTLK: ol  <= ol | blow_addr[OL_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
  import fusectl_pkg::*;
#(
  parameter int unsigned MAG_W    = 8,
  parameter int unsigned FALL_W   = 2,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BLOW_CYC = 4500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fab_init_n,
  input  logic              key_done,
  input  logic [1:0]        key_reg,
  input  logic              key_read,
  input  logic              mid_stb,
  input  logic              high_stb,
  input  logic [LEN_W-1:0]  high_len,
  output logic              read_out,
  output logic [MAG_W-1:0]  f_mag,
  output logic              f_swpol,
  output logic [FALL_W-1:0] f_fall,
  output logic              f_opol,
  output logic              f_lock
);
  localparam int unsigned OL_W = FALL_W + 3;
  localparam int unsigned AW   = (MAG_W > OL_W) ? MAG_W : OL_W;
  localparam int unsigned FW   = MAG_W + 1 + OL_W;

  logic [MAG_W-1:0] mag;
  logic             sp;
  logic [OL_W-1:0]  ol;
  logic [AW-1:0]    addr, mask, fbits;
  logic [31:0]      mask32;
  logic             load, step, clear, blow_fire, read_act, locked, hit;
  regsel_t          cur_reg;
  seq_t             state;
  logic [FW-1:0]    fuses;

  assign locked = ol[OL_W-1];
  assign mask32 = field_mask(cur_reg, MAG_W, OL_W);
  assign mask   = mask32[AW-1:0];
  assign fuses  = {mag, sp, ol};

  fuse_seq #(.LEN_W(LEN_W), .BLOW_CYC(BLOW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_done(key_done), .key_reg(key_reg),
    .key_read(key_read), .mid_stb(mid_stb), .high_stb(high_stb),
    .high_len(high_len), .locked(locked), .load(load), .step(step),
    .clear(clear), .blow_fire(blow_fire), .read_act(read_act),
    .cur_reg(cur_reg), .state(state)
  );

  fuse_addr_shift #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .clear(clear),
    .mask(mask), .addr(addr)
  );

  fuse_array #(.AW(AW), .MAG_W(MAG_W), .OL_W(OL_W)) u_arr (
    .clk(clk), .fab_init_n(fab_init_n), .blow_en(blow_fire),
    .blow_reg(cur_reg), .blow_addr(addr), .mag(mag), .sp(sp), .ol(ol)
  );

  always_comb begin
    fbits = '0;
    case (cur_reg)
      REG_MAG:   fbits[MAG_W-1:0] = mag;
      REG_SWPOL: fbits[0]         = sp;
      REG_OUTLK: fbits[OL_W-1:0]  = ol;
      default:   fbits            = '0;
    endcase
  end

  assign hit      = |(fbits & addr);
  assign read_out = !(read_act && hit);

  assign f_mag   = mag;
  assign f_swpol = sp;
  assign f_fall  = ol[FALL_W-1:0];
  assign f_opol  = ol[FALL_W];
  assign f_lock  = ol[OL_W-1];
endmodule

// File: rtl/fuse_prog_ctrl_chk.sv
module fuse_prog_ctrl_chk
  import fusectl_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned FW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fab_init_n,
  input logic [AW-1:0] addr,
  input logic [FW-1:0] fuses,
  input seq_t          state,
  input logic          key_done,
  input logic          locked,
  input logic          read_act,
  input logic          read_out
);
  // R2
  addr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr));

  // R6
  fuse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !fab_init_n)
    1'b1 |=> ((fuses & $past(fuses)) == $past(fuses)));

  // R5
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n || !fab_init_n)
    1'b1 |=> ($countones(fuses ^ $past(fuses)) <= 1));

  // R5
  spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !fab_init_n)
    (state == S_SPENT) |=> ($stable(fuses) && state == S_SPENT));

  // R9
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || !fab_init_n)
    (locked && key_done && state != S_OPEN) |=> (state != S_OPEN));

  // R7
  idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_act |-> read_out);
endmodule

bind fuse_prog_ctrl fuse_prog_ctrl_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fab_init_n(fab_init_n), .addr(addr),
  .fuses(fuses), .state(state), .key_done(key_done), .locked(locked),
  .read_act(read_act), .read_out(read_out)
);

// File: tb/fuse_prog_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_prog_ctrl_bench;
  localparam int unsigned BLOW = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0, fab_init_n = 1'b0;
  logic key_done = 1'b0, key_read = 1'b0, mid_stb = 1'b0, high_stb = 1'b0;
  logic [1:0] key_reg = 2'd0;
  logic [15:0] high_len = '0;
  logic read_out, f_swpol, f_opol, f_lock;
  logic [7:0] f_mag;
  logic [1:0] f_fall;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mdl [0:2];

  always #10 clk = ~clk;

  fuse_prog_ctrl #(.BLOW_CYC(BLOW)) u_fuse_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .fab_init_n(fab_init_n), .key_done(key_done),
    .key_reg(key_reg), .key_read(key_read), .mid_stb(mid_stb),
    .high_stb(high_stb), .high_len(high_len), .read_out(read_out),
    .f_mag(f_mag), .f_swpol(f_swpol), .f_fall(f_fall), .f_opol(f_opol),
    .f_lock(f_lock)
  );

  function automatic int fw(int r);
    return (r == 0) ? 8 : (r == 1) ? 1 : 5;
  endfunction

  function automatic logic exp_pin(int r, int b);
    if (b >= fw(r)) return 1'b1;
    return !mdl[r][b];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_fuses(input string req);
    chk(req, f_mag, mdl[0]);
    chk(req, f_swpol, mdl[1][0]);
    chk(req, f_fall, mdl[2][1:0]);
    chk(req, f_opol, mdl[2][2]);
    chk(req, f_lock, mdl[2][4]);
  endtask

  task automatic key(input int r, input logic rd);
    key_reg = r[1:0]; key_read = rd; key_done = 1'b1;
    @(negedge clk); key_done = 1'b0;
  endtask

  task automatic mid();
    mid_stb = 1'b1; @(negedge clk); mid_stb = 1'b0;
  endtask

  task automatic high(input int w);
    high_len = w[15:0]; high_stb = 1'b1;
    @(negedge clk); high_stb = 1'b0;
  endtask

  task automatic power_cycle();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic blow_bit(input int r, input int b, input int w);
    key(r, 1'b0);
    for (int i = 0; i < b; i++) mid();
    high(w);
    @(negedge clk);
  endtask

  // R1 R2 R7: read a field bit by bit, one place past the top included
  task automatic readback(input int r, input string req);
    key(r, 1'b1);
    chk(req, read_out, exp_pin(r, 0));
    for (int b = 1; b <= fw(r); b++) begin
      mid();
      chk(req, read_out, exp_pin(r, b));
    end
    high(1);
    chk("R4 read closed by high", read_out, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r, b, w;
    bit lng;
    void'($urandom(32'd2718));
    mdl[0] = '0; mdl[1] = '0; mdl[2] = '0;
    repeat (3) @(negedge clk);
    fab_init_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk_fuses("R11 blank array");
    chk("R7 idle pin", read_out, 1);

    // random blows and readbacks (R3 R4 R5 R6 R7)
    for (int it = 0; it < 24; it++) begin
      r = $urandom_range(0, 2);
      b = $urandom_range(0, fw(r) - 1);
      if (r == 2 && b == 4) b = 3;
      lng = ($urandom_range(0, 3) != 0);
      w = lng ? BLOW + $urandom_range(0, 40) : $urandom_range(1, BLOW - 1);
      blow_bit(r, b, w);
      if (lng) mdl[r][b] = 1'b1;
      chk_fuses(lng ? "R3 long blow" : "R4 short pulse");
      if (lng) begin
        // R5 second attempt in same power cycle ignored
        blow_bit((r + 1) % 3, 0, BLOW + 5);
        chk_fuses("R5 spent until reset");
        key(0, 1'b1);
        chk("R5 read ignored when spent", read_out, 1);
      end else begin
        // R4 session closed: a mid and a long high now do nothing
        mid(); high(BLOW + 1); @(negedge clk);
        chk_fuses("R4 session closed");
      end
      power_cycle();
      chk_fuses("R5 fuses survive reset");
      readback(r, "R7 readback");
    end

    // R2 past the top of the 1-bit field: blow does nothing
    blow_bit(1, 1, BLOW + 3);
    chk_fuses("R2 no bit addressed");
    power_cycle();

    // R10 register 3 ignored, then a valid key still works
    key(3, 1'b1);
    chk("R10 reg3 read ignored", read_out, 1);
    key(3, 1'b0); high(BLOW + 3); @(negedge clk);
    chk_fuses("R10 reg3 blow ignored");
    blow_bit(0, 6, BLOW);
    mdl[0][6] = 1'b1;
    chk("R3 exact threshold blows", f_mag, mdl[0]);
    power_cycle();

    // R8 output polarity fuse reads back raw
    blow_bit(2, 2, BLOW + 7);
    mdl[2][2] = 1'b1;
    power_cycle();
    key(2, 1'b1); mid(); mid();
    chk("R8 polarity bit reads blown", read_out, 0);
    high(1);
    readback(2, "R8 field readback");

    // R12 key collides with a long blow pulse and with a mid strobe
    key(0, 1'b0);
    for (int i = 0; i < 5; i++) mid();
    key_reg = 2'd0; key_read = 1'b1; key_done = 1'b1;
    high_len = 16'(BLOW + 9); high_stb = 1'b1;
    @(negedge clk); key_done = 1'b0; high_stb = 1'b0;
    chk_fuses("R12 key beats blow");
    chk("R12 read session bit0", read_out, exp_pin(0, 0));
    key_reg = 2'd0; key_read = 1'b1; key_done = 1'b1; mid_stb = 1'b1;
    @(negedge clk); key_done = 1'b0; mid_stb = 1'b0;
    chk("R12 key beats mid", read_out, exp_pin(0, 0));
    mid();
    chk("R12 next mid bit1", read_out, exp_pin(0, 1));
    high(1);
    power_cycle();

    // R9 lock: four mids in the output/lock field
    blow_bit(2, 4, BLOW + 2);
    mdl[2][4] = 1'b1;
    chk("R9 lock fuse set", f_lock, 1);
    power_cycle();
    key(0, 1'b1);
    chk("R9 read blocked", read_out, 1);
    mid();
    chk("R9 read blocked after mid", read_out, 1);
    blow_bit(0, 0, BLOW + 2);
    blow_bit(1, 0, BLOW + 2);
    chk_fuses("R9 blow blocked");

    // R11 blank again
    fab_init_n = 1'b0; @(negedge clk); fab_init_n = 1'b1; @(negedge clk);
    mdl[0] = '0; mdl[1] = '0; mdl[2] = '0;
    chk_fuses("R11 re-init");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule